// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Set/Clear Register Bank

This block collects 64 level-sensitive interrupt sources and decides which one the CPU should take. Each source has a 4-bit priority field and an enable bit. The enable bit can only be changed through separate write-one-to-set and write-one-to-clear addresses, so software never needs a read-modify-write. Every cycle the block looks at all sources that are pending, enabled and have a non-zero priority. It picks the one with the highest level and registers that level together with a vector code for the CPU.

Sources 0 to 3 are also four external lines, and a single control bit decides how they are read. With the bit at 1 the lines are four ordinary prioritised sources. With the bit at 0 they form one 4-bit encoded level. In that encoded mode the level is requested directly under the enable of source 0.

Software sees a 64-bit register port with 8-byte spacing. The port accepts one access in every cycle it is presented and never applies back-pressure. Read data comes back one cycle later, qualified by a valid strobe.

Top module: `prio_intc`

## Requirements
- R1: After reset all enables are 0, all priority fields are 0, the mode bit is 0, and `irq_level` and `irq_vector` are 0.
- R2: A read presented on `reg_en` with `reg_we` low returns its data on `reg_rdata` with `rd_valid` high in the following cycle. Bits 63..32 of every read are 0, and an unmapped address reads 0.
- R3: Source n maps to bit n of the low register of a pair when n < 32, and to bit n-32 of the high register when n >= 32. The enable pairs are:
  - set at 0x70 (low) and 0x78 (high);
  - clear at 0x80 (low) and 0x88 (high).
  Writing a 1 sets or clears the matching enable, a 0 leaves it untouched, and reading any of these four addresses returns the current enables.
- R4: The priority of source n is the 4-bit field at bits 4*(n mod 8)+3 .. 4*(n mod 8) of the register at 0x10 + 8*(n/8). The eight priority registers are readable and writable.
- R5: Bit 0 of the control register is the line-mode bit. Writing 1 to bit 0 at 0x00 sets it and writing 1 to bit 0 at 0x08 clears it, and both addresses read it back in bit 0.
- R6: Among the candidates, the highest priority wins, and on equal priority the lowest source number wins.
- R7: A source whose priority field is 0, or whose enable is 0, never produces a request.
- R8: `irq_level` is the winning priority and `irq_vector` is 0x200 + 0x20 * winner. Both are 0 when there is no candidate. Both are registered, so they follow a change of inputs or registers one clock edge later.
- R9: With the mode bit at 1, lines `src_in[3:0]` are four individual sources 0 to 3 using their own enables and priority fields.
- R10: With the mode bit at 0, the value `src_in[3:0]` (bit 3 most significant) is a requested level gated by the enable of source 0. It uses vector 0x200, and sources 1 to 3 make no individual request.
- R11: Source status reads raw `src_in`, at 0x50 (low) and 0x58 (high). Request status reads `src_in` AND enables, at 0x60 (low) and 0x68 (high). Writes to these four addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 64 | Level-sensitive sources; bits 3..0 are the external lines |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| irq_level | output | 4 | Winning priority level, 0 = none |
| irq_vector | output | 12 | Vector code of the winner, 0 = none |

## Verification
A write takes effect at the clock edge that accepts it, so the interrupt outputs follow one edge later. A change on `src_in` shows on the outputs after a single edge. Read data and `rd_valid` are due at the edge after the read is presented. The bench drives every input on the falling edge and samples outputs on a later falling edge. After a write it waits one full extra cycle before it checks the outputs, and it samples read data on the falling edge right after the accepting edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC        = 64;
  localparam int PRIO_W         = 4;
  localparam int HALF           = 32;
  localparam int NUM_HALF       = NUM_SRC / HALF;
  localparam int FIELDS_PER_REG = 8;
  localparam int NUM_PRIO_REG   = NUM_SRC / FIELDS_PER_REG;
  localparam int PREG_BITS      = FIELDS_PER_REG * PRIO_W;
  localparam int IDX_W          = $clog2(NUM_SRC);
  localparam int DATA_W         = 64;
  localparam int ADDR_W         = 8;
  localparam int VEC_W          = 12;
  localparam int NUM_LINES      = 4;
  localparam int REG_STRIDE     = 8;
  localparam int VEC_SHIFT      = 5;

  localparam logic [VEC_W-1:0]  VEC_BASE    = 12'h200;

  localparam logic [ADDR_W-1:0] A_CTRL_SET  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CTRL_CLR  = 8'h08;
  localparam logic [ADDR_W-1:0] A_PRIO_BASE = 8'h10;
  localparam logic [ADDR_W-1:0] A_SRC_LO    = 8'h50;
  localparam logic [ADDR_W-1:0] A_REQ_LO    = 8'h60;
  localparam logic [ADDR_W-1:0] A_ENSET_LO  = 8'h70;
  localparam logic [ADDR_W-1:0] A_ENCLR_LO  = 8'h80;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic [IDX_W-1:0]  idx;
  } cand_t;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_en,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  input  logic [NUM_SRC-1:0]         src_in,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic                       rd_valid,
  output logic [NUM_SRC-1:0]         en_q,
  output logic [NUM_SRC*PRIO_W-1:0]  prio_q,
  output logic                       mode_q
);
  logic wr_acc;
  logic rd_acc;
  logic [DATA_W-HALF-1:0] wdata_hi_unused;
  logic [DATA_W-1:0] rd_next;

  assign wr_acc = reg_en && reg_we;
  assign rd_acc = reg_en && !reg_we;
  assign wdata_hi_unused = reg_wdata[DATA_W-1:HALF];

  // line-mode control bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (wr_acc && reg_addr == A_CTRL_SET && reg_wdata[0]) begin
      mode_q <= 1'b1;
    end else if (wr_acc && reg_addr == A_CTRL_CLR && reg_wdata[0]) begin
      mode_q <= 1'b0;
    end
  end

  // enable halves, changed only through set/clear addresses
  for (genvar h = 0; h < NUM_HALF; h++) begin : g_en
    localparam logic [ADDR_W-1:0] SET_A = A_ENSET_LO + ADDR_W'(h * REG_STRIDE);
    localparam logic [ADDR_W-1:0] CLR_A = A_ENCLR_LO + ADDR_W'(h * REG_STRIDE);
    logic [HALF-1:0] half_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        half_q <= '0;
      end else if (wr_acc && reg_addr == SET_A) begin
        half_q <= half_q | reg_wdata[HALF-1:0];
      end else if (wr_acc && reg_addr == CLR_A) begin
        half_q <= half_q & ~reg_wdata[HALF-1:0];
      end
    end
    assign en_q[h*HALF +: HALF] = half_q;
  end

  // packed priority registers
  for (genvar r = 0; r < NUM_PRIO_REG; r++) begin : g_prio
    localparam logic [ADDR_W-1:0] PR_A = A_PRIO_BASE + ADDR_W'(r * REG_STRIDE);
    logic [PREG_BITS-1:0] preg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        preg_q <= '0;
      end else if (wr_acc && reg_addr == PR_A) begin
        preg_q <= reg_wdata[PREG_BITS-1:0];
      end
    end
    assign prio_q[r*PREG_BITS +: PREG_BITS] = preg_q;
  end

  // read decode
  always_comb begin
    rd_next = '0;
    if (reg_addr == A_CTRL_SET || reg_addr == A_CTRL_CLR) begin
      rd_next[0] = mode_q;
    end
    for (int h = 0; h < NUM_HALF; h++) begin
      if (reg_addr == A_SRC_LO + ADDR_W'(h * REG_STRIDE)) begin
        rd_next[HALF-1:0] = src_in[h*HALF +: HALF];
      end
      if (reg_addr == A_REQ_LO + ADDR_W'(h * REG_STRIDE)) begin
        rd_next[HALF-1:0] = src_in[h*HALF +: HALF] & en_q[h*HALF +: HALF];
      end
      if (reg_addr == A_ENSET_LO + ADDR_W'(h * REG_STRIDE) ||
          reg_addr == A_ENCLR_LO + ADDR_W'(h * REG_STRIDE)) begin
        rd_next[HALF-1:0] = en_q[h*HALF +: HALF];
      end
    end
    for (int r = 0; r < NUM_PRIO_REG; r++) begin
      if (reg_addr == A_PRIO_BASE + ADDR_W'(r * REG_STRIDE)) begin
        rd_next[PREG_BITS-1:0] = prio_q[r*PREG_BITS +: PREG_BITS];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= rd_acc;
      if (rd_acc) begin
        reg_rdata <= rd_next;
      end
    end
  end
endmodule

// File: rtl/intc_src_cond.sv
module intc_src_cond
  import intc_pkg::*;
(
  input  logic [NUM_SRC-1:0]         src_in,
  input  logic [NUM_SRC-1:0]         en_q,
  input  logic [NUM_SRC*PRIO_W-1:0]  prio_q,
  input  logic                       mode_q,
  output logic [NUM_SRC*PRIO_W-1:0]  cand_prio
);
  logic [NUM_LINES-1:0] line_level;
  assign line_level = src_in[NUM_LINES-1:0];

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic [PRIO_W-1:0] own_prio;
    assign own_prio = (src_in[k] && en_q[k]) ? prio_q[k*PRIO_W +: PRIO_W] : '0;
    if (k == 0) begin : g_enc
      // encoded lines ride on source 0
      assign cand_prio[k*PRIO_W +: PRIO_W] =
        mode_q ? own_prio : (en_q[0] ? PRIO_W'(line_level) : '0);
    end else if (k < NUM_LINES) begin : g_line
      assign cand_prio[k*PRIO_W +: PRIO_W] = mode_q ? own_prio : '0;
    end else begin : g_plain
      assign cand_prio[k*PRIO_W +: PRIO_W] = own_prio;
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
(
  input  logic [NUM_SRC*PRIO_W-1:0] cand_prio,
  output logic [PRIO_W-1:0]         win_prio,
  output logic [IDX_W-1:0]          win_idx
);
  localparam int NODES = 2 * NUM_SRC - 1;
  cand_t node [NODES];

  // leaves in source order, heap layout keeps lower indices to the left
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_leaf
    assign node[NUM_SRC-1+k] = '{prio: cand_prio[k*PRIO_W +: PRIO_W], idx: IDX_W'(k)};
  end

  // right child replaces left only when strictly higher
  for (genvar i = 0; i < NUM_SRC - 1; i++) begin : g_node
    assign node[i] = (node[2*i+2].prio > node[2*i+1].prio) ? node[2*i+2] : node[2*i+1];
  end

  assign win_prio = node[0].prio;
  assign win_idx  = node[0].idx;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_in,
  input  logic                 reg_en,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 rd_valid,
  output logic [PRIO_W-1:0]    irq_level,
  output logic [VEC_W-1:0]     irq_vector
);
  logic [NUM_SRC-1:0]        en_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic                      mode_q;
  logic [NUM_SRC*PRIO_W-1:0] cand_prio;
  logic [PRIO_W-1:0]         win_prio;
  logic [IDX_W-1:0]          win_idx;

  intc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .src_in    (src_in),
    .reg_rdata (reg_rdata),
    .rd_valid  (rd_valid),
    .en_q      (en_q),
    .prio_q    (prio_q),
    .mode_q    (mode_q)
  );

  intc_src_cond u_cond (
    .src_in    (src_in),
    .en_q      (en_q),
    .prio_q    (prio_q),
    .mode_q    (mode_q),
    .cand_prio (cand_prio)
  );

  intc_arbiter u_arb (
    .cand_prio (cand_prio),
    .win_prio  (win_prio),
    .win_idx   (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level  <= '0;
      irq_vector <= '0;
    end else begin
      irq_level  <= win_prio;
      irq_vector <= (win_prio != '0) ? VEC_BASE + (VEC_W'(win_idx) << VEC_SHIFT) : '0;
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_en,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [HALF-1:0]    wdata_lo,
  input logic               rd_valid,
  input logic [NUM_SRC-1:0] en_q,
  input logic               mode_q,
  input logic [PRIO_W-1:0]  irq_level,
  input logic [VEC_W-1:0]   irq_vector
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (irq_level == '0 && irq_vector == '0 && !mode_q && en_q == '0);
    end
  end

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && reg_addr == A_ENSET_LO) |=>
      en_q[HALF-1:0] == ($past(en_q[HALF-1:0]) | $past(wdata_lo)));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && reg_addr == A_ENCLR_LO + 8'h08) |=>
      en_q[NUM_SRC-1:HALF] == ($past(en_q[NUM_SRC-1:HALF]) & ~$past(wdata_lo)));

  // R5
  mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && reg_addr == A_CTRL_SET && wdata_lo[0]) |=> mode_q);

  // R5
  mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && reg_addr == A_CTRL_CLR && wdata_lo[0]) |=> !mode_q);

  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_we) |=> rd_valid);

  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_en && !reg_we) |=> !rd_valid);

  // R8
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) |-> (irq_vector == '0));

  // R8
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (irq_vector[VEC_SHIFT-1:0] == '0 && irq_vector >= VEC_BASE));
endmodule

bind prio_intc intc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_en     (reg_en),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .wdata_lo   (reg_wdata[31:0]),
  .rd_valid   (rd_valid),
  .en_q       (en_q),
  .mode_q     (mode_q),
  .irq_level  (irq_level),
  .irq_vector (irq_vector)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  import intc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic                clk = 1'b0;
  logic                rst_n = 1'b1;
  logic [NUM_SRC-1:0]  src_in = '0;
  logic                reg_en = 1'b0;
  logic                reg_we = 1'b0;
  logic [ADDR_W-1:0]   reg_addr = '0;
  logic [DATA_W-1:0]   reg_wdata = '0;
  logic [DATA_W-1:0]   reg_rdata;
  logic                rd_valid;
  logic [PRIO_W-1:0]   irq_level;
  logic [VEC_W-1:0]    irq_vector;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc u_prio_intc (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_in     (src_in),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .rd_valid   (rd_valid),
    .irq_level  (irq_level),
    .irq_vector (irq_vector)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata;
    check("R2", "rd_valid after read", {63'b0, rd_valid}, 64'h1);
  endtask

  task automatic clean();
    src_in = '0;
    wr(8'h80, 64'hFFFF_FFFF);
    wr(8'h88, 64'hFFFF_FFFF);
    for (int r = 0; r < 8; r++) wr(8'h10 + 8'(r * 8), 64'h0);
    wr(8'h08, 64'h1);
    tick();
  endtask

  task automatic t_reset();
    logic [63:0] d;
    check("R1", "irq_level after reset", {60'b0, irq_level}, 64'h0);
    check("R1", "irq_vector after reset", {52'b0, irq_vector}, 64'h0);
    check("R2", "rd_valid idle", {63'b0, rd_valid}, 64'h0);
    rd(8'h70, d); check("R1", "enables low", d, 64'h0);
    rd(8'h78, d); check("R1", "enables high", d, 64'h0);
    rd(8'h00, d); check("R1", "mode bit", d, 64'h0);
    rd(8'h10, d); check("R1", "prio reg 0", d, 64'h0);
    rd(8'hF8, d); check("R2", "unmapped read", d, 64'h0);
  endtask

  task automatic t_enable();
    logic [63:0] d;
    clean();
    wr(8'h70, 64'hFFFF_FFFF_0000_00F0);
    rd(8'h70, d); check("R3", "set low, upper data bits dropped", d, 64'hF0);
    wr(8'h80, 64'h30);
    rd(8'h80, d); check("R3", "clear low readback", d, 64'hC0);
    wr(8'h70, 64'h0);
    rd(8'h70, d); check("R3", "zero write leaves enables", d, 64'hC0);
    wr(8'h78, 64'h8000_0001);
    rd(8'h88, d); check("R3", "high half set (sources 32,63)", d, 64'h8000_0001);
    rd(8'h70, d); check("R3", "low half unaffected by high write", d, 64'hC0);
  endtask

  task automatic t_priority();
    logic [63:0] d;
    clean();
    wr(8'h18, 64'h0007_0030);          // source 9 -> 3, source 12 -> 7
    rd(8'h18, d); check("R4", "prio reg 1 readback", d, 64'h0007_0030);
    wr(8'h70, 64'h1200);
    src_in[9] = 1'b1; src_in[12] = 1'b1;
    tick();
    check("R6", "higher prio wins level", {60'b0, irq_level}, 64'h7);
    check("R8", "vector for source 12", {52'b0, irq_vector}, 64'h380);
    src_in[12] = 1'b0;
    tick();
    check("R8", "level one edge after src drop", {60'b0, irq_level}, 64'h3);
    check("R8", "vector for source 9", {52'b0, irq_vector}, 64'h320);
    wr(8'h48, 64'h1234_5678);          // source 63 -> 1
    rd(8'h48, d); check("R4", "prio reg 7 readback", d, 64'h1234_5678);
    src_in = '0; src_in[63] = 1'b1;
    wr(8'h78, 64'h8000_0000);
    tick();
    check("R4", "source 63 uses top nibble", {60'b0, irq_level}, 64'h1);
    check("R8", "vector for source 63", {52'b0, irq_vector}, 64'h9E0);
  endtask

  task automatic t_tie();
    logic [63:0] d;
    clean();
    wr(8'h38, 64'h55);                 // sources 40,41 -> 5
    wr(8'h78, 64'h300);
    src_in[40] = 1'b1; src_in[41] = 1'b1;
    tick();
    check("R6", "tie level", {60'b0, irq_level}, 64'h5);
    check("R6", "tie goes to lower index 40", {52'b0, irq_vector}, 64'h700);
    rd(8'h68, d); check("R11", "request status high", d, 64'h300);
  endtask

  task automatic t_masking();
    clean();
    wr(8'h40, 64'h4000);               // source 50 -> 0, source 51 -> 4
    wr(8'h78, 64'h4_0000);             // enable 50
    src_in[50] = 1'b1; src_in[51] = 1'b1;
    tick();
    check("R7", "prio 0 and disabled give no request", {60'b0, irq_level}, 64'h0);
    check("R8", "idle vector", {52'b0, irq_vector}, 64'h0);
    wr(8'h78, 64'h8_0000);             // enable 51
    tick();
    check("R7", "source 51 once enabled", {60'b0, irq_level}, 64'h4);
    check("R8", "vector for source 51", {52'b0, irq_vector}, 64'h860);
  endtask

  task automatic t_modes();
    logic [63:0] d;
    clean();
    wr(8'h00, 64'h1);
    rd(8'h08, d); check("R5", "mode set readback", d, 64'h1);
    wr(8'h10, 64'h900);                // source 2 -> 9
    wr(8'h70, 64'h4);
    src_in[3:0] = 4'b0110;
    tick();
    check("R9", "individual line 2 level", {60'b0, irq_level}, 64'h9);
    check("R9", "individual line 2 vector", {52'b0, irq_vector}, 64'h240);
    wr(8'h08, 64'h1);
    rd(8'h00, d); check("R5", "mode clear readback", d, 64'h0);
    check("R10", "encoded without enable 0", {60'b0, irq_level}, 64'h0);
    wr(8'h70, 64'h1);
    tick();
    check("R10", "encoded level", {60'b0, irq_level}, 64'h6);
    check("R10", "encoded vector", {52'b0, irq_vector}, 64'h200);
    src_in[3:0] = 4'b0000;
    tick();
    check("R10", "encoded zero is idle", {60'b0, irq_level}, 64'h0);
  endtask

  task automatic t_status();
    logic [63:0] d;
    clean();
    src_in = 64'h0000_0003_8000_0010;
    wr(8'h70, 64'h10);
    wr(8'h78, 64'h1);
    rd(8'h50, d); check("R11", "source status low", d, 64'h8000_0010);
    rd(8'h58, d); check("R11", "source status high", d, 64'h3);
    rd(8'h60, d); check("R11", "request status low", d, 64'h10);
    wr(8'h50, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(8'h60, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(8'h50, d); check("R11", "status write ignored", d, 64'h8000_0010);
    rd(8'h70, d); check("R11", "enables untouched by status write", d, 64'h10);
  endtask

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_enable();
    t_priority();
    t_tie();
    t_masking();
    t_modes();
    t_status();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1..all actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule